// File: doc/BRIEF.md
# HDLC Multidrop Bus Access Controller

This block controls when an HDLC transmitter may drive a shared multidrop line, and what happens when another station is driving the line at the same time. When the transmit engine starts a frame, the block raises a request-to-send enable. In bus mode it then compares every bit it sends with the bit it reads back from the line. A mismatch is a collision. On a collision the block drops its enable, reports a lost-clear-to-send pulse, and makes one of two requests to the engine. It asks for a restart if automatic retransmission is allowed. Otherwise it asks the engine to abandon the frame.

A restart is allowed only when retransmission is enabled and the collision happened while the engine was sending the first or second buffer of the frame. After a restart request, the block holds the enable low until the line has been seen idle (high) for a set number of consecutive bit periods. It then raises the enable again, and the engine sends the frame from its start. An optional delayed mode holds the enable off for one extra bit period after the frame starts. The block can also switch off the local receiver for as long as it is transmitting.

Top module: `hdlc_bus_access`

## Requirements
- R1: After reset, `rts` is 0, `lost_cts`, `restart_req` and `abort_req` are 0, and `rx_enable` is 1.
- R2: When `frame_start` is seen with the block idle, `rts` is 1 from the next clock. It stays 1 until `frame_end` or a collision, and is 0 on the clock after `frame_end`.
- R3: With `mode_bus`=1 and `mode_rts_delay`=1, `rts` stays 0 after the frame starts. It becomes 1 on the clock after the first `bit_en` of the transmission. This is a delay of exactly one bit.
- R4: With `mode_bus`=0, `mode_rts_delay` has no effect, and `rts` follows R2 timing.
- R5: With `mode_bus`=1, while transmitting, a `bit_en` cycle in which `tx_bit` differs from `bus_rx` is a collision. On the next clock `rts` is 0 and `lost_cts` is 1 for exactly one clock.
- R6: On a collision with `mode_retx`=1 and `buf_idx` less than 2, `restart_req` is 1 for one clock, together with `lost_cts`.
- R7: On any other collision, `abort_req` is 1 for one clock, together with `lost_cts`, and the block returns to idle. `restart_req` stays 0.
- R8: After a restart, `rts` becomes 1 only on the clock after the IDLE_BITS-th consecutive `bit_en` sample with `bus_rx`=1. Any `bit_en` sample with `bus_rx`=0 starts the count again.
- R9: `rx_enable` is 0 while the block is transmitting and `mode_rx_off`=1. It is 1 at all other times.
- R10: With `mode_bus`=0, a mismatch between `tx_bit` and `bus_rx` is not a collision. `rts` stays 1 and no status pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-clock strobe per bit period |
| frame_start | input | 1 | Transmit engine has a frame ready |
| frame_end | input | 1 | Transmit engine has sent the last bit of the frame |
| buf_idx | input | BUF_IDX_W | Index of the buffer being sent within the frame (0 = first) |
| tx_bit | input | 1 | Bit being driven onto the line |
| bus_rx | input | 1 | Bit read back from the shared line |
| mode_retx | input | 1 | Allow automatic retransmission |
| mode_bus | input | 1 | Multidrop bus mode with collision detection |
| mode_rts_delay | input | 1 | Delay `rts` by one bit (bus mode only) |
| mode_rx_off | input | 1 | Switch the receiver off while transmitting |
| rts | output | 1 | Line drive enable |
| restart_req | output | 1 | Pulse: rewind and resend the frame |
| abort_req | output | 1 | Pulse: abandon the frame |
| lost_cts | output | 1 | Pulse: the frame lost the bus |
| rx_enable | output | 1 | Receiver gate (1 = receive) |

## Verification
The bench forces collisions in buffer 0 and buffer 2 with retransmission enabled, and one collision with retransmission disabled. A wrong buffer limit shows up as a restart where an abort is expected, or the other way round. The idle wait after a restart is broken by a single low bit. A counter that does not restart its count raises `rts` too early. Delayed mode is tested both inside and outside bus mode. An enable that ignores the mode gating is high a bit late or early. A mismatch outside bus mode checks that detection is not left always on. Each status pulse is also checked to fall after one clock.

// File: rtl/hdlc_bus_pkg.sv
package hdlc_bus_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_SEND = 2'd1,
      ACC_WAIT = 2'd2
   } acc_state_e;
endpackage

// File: rtl/hdlc_bus_collide.sv
module hdlc_bus_collide (
   input  logic bit_en,
   input  logic sending,
   input  logic bus_mode,
   input  logic tx_bit,
   input  logic bus_rx,
   output logic hit
);
   // Sample-back compare, qualified by bus mode and an active transmission
   always_comb hit = bit_en & sending & bus_mode & (tx_bit ^ bus_rx);
endmodule

// File: rtl/hdlc_bus_idle_cnt.sv
module hdlc_bus_idle_cnt #(
   parameter int IDLE_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bit_en,
   input  logic bus_rx,
   output logic idle_ok
);
   localparam int CNT_W = (IDLE_BITS > 1) ? $clog2(IDLE_BITS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

   generate
      if (IDLE_BITS == 1) begin : g_single
         always_comb idle_ok = bit_en & bus_rx;
      end else begin : g_count
         logic [CNT_W-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else if (clear)
               run_q <= '0;
            else if (bit_en)
               run_q <= bus_rx ? run_q + CNT_W'(1) : '0;
         end
         always_comb idle_ok = bit_en & bus_rx & (run_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/hdlc_bus_rts_gen.sv
module hdlc_bus_rts_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sending,
   input  logic bit_en,
   input  logic dly_mode,
   output logic rts
);
   logic first_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         first_pend_q <= 1'b0;
      else if (start)
         first_pend_q <= 1'b1;
      else if (sending && bit_en)
         first_pend_q <= 1'b0;
   end

   always_comb rts = sending & ~(dly_mode & first_pend_q);
endmodule

// File: rtl/hdlc_bus_access.sv
module hdlc_bus_access #(
   parameter int BUF_IDX_W = 3,
   parameter int RETX_BUFS = 2,
   parameter int IDLE_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 frame_start,
   input  logic                 frame_end,
   input  logic [BUF_IDX_W-1:0] buf_idx,
   input  logic                 tx_bit,
   input  logic                 bus_rx,
   input  logic                 mode_retx,
   input  logic                 mode_bus,
   input  logic                 mode_rts_delay,
   input  logic                 mode_rx_off,
   output logic                 rts,
   output logic                 restart_req,
   output logic                 abort_req,
   output logic                 lost_cts,
   output logic                 rx_enable
);
   import hdlc_bus_pkg::*;

   localparam logic [BUF_IDX_W:0] RETX_LIM = (BUF_IDX_W + 1)'(RETX_BUFS);

   generate
      if (BUF_IDX_W < 1) begin : g_bad_w
         $error("BUF_IDX_W must be at least 1");
      end
      if (IDLE_BITS < 1) begin : g_bad_idle
         $error("IDLE_BITS must be at least 1");
      end
      if (RETX_BUFS < 0 || RETX_BUFS > (1 << BUF_IDX_W)) begin : g_bad_retx
         $error("RETX_BUFS out of range for BUF_IDX_W");
      end
   endgenerate

   acc_state_e state_q;
   logic       sending, hit, idle_ok, start, retry_ok;

   always_comb sending = (state_q == ACC_SEND);

   generate
      if (RETX_BUFS == 0) begin : g_no_retry
         always_comb retry_ok = 1'b0;
      end else begin : g_retry
         always_comb retry_ok = mode_retx & ({1'b0, buf_idx} < RETX_LIM);
      end
   endgenerate

   hdlc_bus_collide i_collide (
      .bit_en   (bit_en),
      .sending  (sending),
      .bus_mode (mode_bus),
      .tx_bit   (tx_bit),
      .bus_rx   (bus_rx),
      .hit      (hit)
   );

   hdlc_bus_idle_cnt #(.IDLE_BITS(IDLE_BITS)) i_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state_q != ACC_WAIT),
      .bit_en  (bit_en),
      .bus_rx  (bus_rx),
      .idle_ok (idle_ok)
   );

   always_comb start = ((state_q == ACC_IDLE) & frame_start) |
                       ((state_q == ACC_WAIT) & idle_ok);

   hdlc_bus_rts_gen i_rts (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .sending  (sending),
      .bit_en   (bit_en),
      .dly_mode (mode_bus & mode_rts_delay),
      .rts      (rts)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ACC_IDLE;
         lost_cts    <= 1'b0;
         restart_req <= 1'b0;
         abort_req   <= 1'b0;
      end else begin
         lost_cts    <= 1'b0;
         restart_req <= 1'b0;
         abort_req   <= 1'b0;
         unique case (state_q)
            ACC_IDLE: if (frame_start) state_q <= ACC_SEND;
            ACC_SEND: begin
               if (hit) begin
                  lost_cts <= 1'b1;
                  if (retry_ok) begin
                     restart_req <= 1'b1;
                     state_q     <= ACC_WAIT;
                  end else begin
                     abort_req <= 1'b1;
                     state_q   <= ACC_IDLE;
                  end
               end else if (frame_end) begin
                  state_q <= ACC_IDLE;
               end
            end
            ACC_WAIT: if (idle_ok) state_q <= ACC_SEND;
            default:  state_q <= ACC_IDLE;
         endcase
      end
   end

   always_comb rx_enable = ~(mode_rx_off & sending);
endmodule

// File: rtl/hdlc_bus_access_chk.sv
module hdlc_bus_access_chk #(
   parameter int BUF_IDX_W = 3,
   parameter int RETX_BUFS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [BUF_IDX_W-1:0] buf_idx,
   input logic                 mode_retx,
   input logic                 mode_rx_off,
   input logic                 rts,
   input logic                 restart_req,
   input logic                 abort_req,
   input logic                 lost_cts,
   input logic                 rx_enable
);
   p_lost_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lost_cts |=> !lost_cts);

   p_rts_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lost_cts |-> !rts);

   p_restart_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> lost_cts && $past(mode_retx) &&
                      ({1'b0, $past(buf_idx)} < (BUF_IDX_W + 1)'(RETX_BUFS)));

   p_abort_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> lost_cts && !restart_req);

   p_status_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lost_cts |-> (restart_req || abort_req));

   p_rx_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rts && mode_rx_off) |-> !rx_enable);
endmodule

bind hdlc_bus_access hdlc_bus_access_chk #(
   .BUF_IDX_W (BUF_IDX_W),
   .RETX_BUFS (RETX_BUFS)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .buf_idx     (buf_idx),
   .mode_retx   (mode_retx),
   .mode_rx_off (mode_rx_off),
   .rts         (rts),
   .restart_req (restart_req),
   .abort_req   (abort_req),
   .lost_cts    (lost_cts),
   .rx_enable   (rx_enable)
);

// File: tb/test_hdlc_bus_access.sv
module test_hdlc_bus_access;
   localparam int IW   = 3;
   localparam int IDLE = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 0, frame_start = 0, frame_end = 0, tx_bit = 1, bus_rx = 1;
   logic [IW-1:0] buf_idx = '0;
   logic mode_retx = 0, mode_bus = 1, mode_rts_delay = 0, mode_rx_off = 0;
   logic rts, restart_req, abort_req, lost_cts, rx_enable;
   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   hdlc_bus_access #(.BUF_IDX_W(IW), .RETX_BUFS(2), .IDLE_BITS(IDLE)) i_hdlc_bus_access (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
      .frame_end(frame_end), .buf_idx(buf_idx), .tx_bit(tx_bit), .bus_rx(bus_rx),
      .mode_retx(mode_retx), .mode_bus(mode_bus), .mode_rts_delay(mode_rts_delay),
      .mode_rx_off(mode_rx_off), .rts(rts), .restart_req(restart_req),
      .abort_req(abort_req), .lost_cts(lost_cts), .rx_enable(rx_enable));

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic send_bit(input logic t, input logic r);
      bit_en = 1; tx_bit = t; bus_rx = r;
      step();
      bit_en = 0; tx_bit = 1; bus_rx = 1;
   endtask

   task automatic begin_frame();
      frame_start = 1;
      step();
      frame_start = 0;
   endtask

   task automatic end_frame();
      frame_end = 1;
      step();
      frame_end = 0;
   endtask

   task automatic t_reset();
      check("R1", "rts", rts, 0);
      check("R1", "lost_cts", lost_cts, 0);
      check("R1", "restart_req", restart_req, 0);
      check("R1", "abort_req", abort_req, 0);
      check("R1", "rx_enable", rx_enable, 1);
   endtask

   task automatic t_normal_frame();
      mode_bus = 1; mode_rts_delay = 0; mode_rx_off = 1;
      begin_frame();
      check("R2", "rts after start", rts, 1);
      check("R9", "rx gated", rx_enable, 0);
      for (int i = 0; i < 4; i++) send_bit(i[0], i[0]);
      check("R2", "rts held", rts, 1);
      check("R5", "no lost on match", lost_cts, 0);
      end_frame();
      check("R2", "rts after end", rts, 0);
      check("R9", "rx released", rx_enable, 1);
      mode_rx_off = 0;
      begin_frame();
      check("R9", "rx kept when off", rx_enable, 1);
      end_frame();
   endtask

   task automatic t_delay_bus();
      mode_bus = 1; mode_rts_delay = 1;
      begin_frame();
      check("R3", "rts held off", rts, 0);
      step();
      check("R3", "rts still off w/o bit", rts, 0);
      send_bit(1, 1);
      check("R3", "rts after one bit", rts, 1);
      end_frame();
      mode_rts_delay = 0;
   endtask

   task automatic t_delay_nobus();
      mode_bus = 0; mode_rts_delay = 1;
      begin_frame();
      check("R4", "rts immediate", rts, 1);
      send_bit(1, 0);
      check("R10", "rts kept on mismatch", rts, 1);
      check("R10", "no lost on mismatch", lost_cts, 0);
      check("R10", "no abort on mismatch", abort_req, 0);
      end_frame();
      mode_bus = 1; mode_rts_delay = 0;
   endtask

   task automatic t_retx_buf0();
      mode_retx = 1; buf_idx = 0;
      begin_frame();
      send_bit(1, 1);
      send_bit(1, 0);
      check("R5", "rts dropped", rts, 0);
      check("R5", "lost pulse", lost_cts, 1);
      check("R6", "restart pulse", restart_req, 1);
      check("R6", "no abort", abort_req, 0);
      step();
      check("R5", "lost one clock", lost_cts, 0);
      check("R6", "restart one clock", restart_req, 0);
      for (int i = 0; i < IDLE - 1; i++) send_bit(1, 1);
      check("R8", "rts before idle done", rts, 0);
      send_bit(1, 1);
      check("R8", "rts after idle", rts, 1);
      end_frame();
      check("R2", "idle after end", rts, 0);
   endtask

   task automatic t_retx_buf1_break();
      mode_retx = 1; buf_idx = 1;
      begin_frame();
      send_bit(0, 1);
      check("R6", "restart in buf1", restart_req, 1);
      for (int i = 0; i < IDLE - 1; i++) send_bit(1, 1);
      send_bit(1, 0);
      for (int i = 0; i < IDLE - 1; i++) send_bit(1, 1);
      check("R8", "count restarted", rts, 0);
      send_bit(1, 1);
      check("R8", "rts after full idle", rts, 1);
      end_frame();
   endtask

   task automatic t_abort_buf2();
      mode_retx = 1; buf_idx = 2;
      begin_frame();
      send_bit(1, 0);
      check("R7", "abort in buf2", abort_req, 1);
      check("R7", "no restart buf2", restart_req, 0);
      check("R7", "lost with abort", lost_cts, 1);
      step();
      check("R7", "abort one clock", abort_req, 0);
      for (int i = 0; i < IDLE + 2; i++) send_bit(1, 1);
      check("R7", "stays idle", rts, 0);
   endtask

   task automatic t_abort_noretx();
      mode_retx = 0; buf_idx = 0;
      begin_frame();
      send_bit(0, 1);
      check("R7", "abort retx off", abort_req, 1);
      check("R7", "no restart retx off", restart_req, 0);
      check("R5", "rts off", rts, 0);
      begin_frame();
      check("R2", "new frame accepted", rts, 1);
      end_frame();
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_normal_frame();
      t_delay_bus();
      t_delay_nobus();
      t_retx_buf0();
      t_retx_buf1_break();
      t_abort_buf2();
      t_abort_noretx();
      done = 1;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule